// File: doc/BRIEF.md
# Pre-adder Operand Input Stage

This block is the operand front end of a multiply path. It accepts a signed A operand and a signed B operand, each taken from either a direct input or a cascade input, plus a D operand. A and B each pass through zero, one or two input registers. A registered control word picks, at run time, whether the multiplier sees the first or the second register of each operand. It also picks whether the pre-adder adds or subtracts.

The pre-adder forms D plus or minus one partner operand, A or B, chosen by a parameter. Its result can be held in an optional pipeline register. The selected A and B operands and the pre-adder result go to the multiplier. The value in the last register of each operand goes on to the next unit as a cascade output. Each register stage has its own clock enable. Each operand has its own synchronous reset. An active-low global reset clears every register at once, but only when the reset-mode parameter selects asynchronous mode.

Top module: `preadd_operand_stage`

## Requirements
- R1: With `A_DEPTH`=2, the A operand reaches `a_sel_o` one clock after capture when control bit 0 is 1, and two clocks after capture when that bit is 0. `acout_o` always follows the two-clock path. With depth 1, both paths take one clock.
- R2: The B path follows the same rule, steered by control bit 4. With `B_DEPTH`=1, bit 4 = 1 selects the first B register and bit 4 = 0 selects the second.
- R3: With a depth parameter of 0, the operand output and cascade output equal the chosen input in the same cycle, with no clock edge.
- R4: A register stage whose clock enable is low keeps its value.
- R5: A per-operand synchronous reset clears both registers of that operand on the next edge and leaves the other operand unchanged.
- R6: The 5-bit control word is captured in a register. A change on `mode_i` acts one clock later. The register holds while `ce_mode_i` is low and clears to 0 on `rst_mode_i`.
- R7: With control bit 3 at 0, the pre-adder gives D plus the partner operand. The partner is A when `PRE_SEL_B`=0 and B when it is 1, and B is sign-extended to D's width.
- R8: With control bit 3 at 1, the pre-adder gives D minus the partner in two's complement, wrapping modulo 2^D_W.
- R9: With `AD_REG`=1, `ad_o` shows the pre-adder result one clock later. It holds while `ce_ad_i` is low and clears on `rst_ad_i`.
- R10: A cascade-select parameter picks the direct or the cascade input for each operand. The cascade outputs carry the value of the last register stage.
- R11: With `ASYNC_MODE`=1, a low `rst_ni` clears every register at once, without waiting for a clock. With `ASYNC_MODE`=0, `rst_ni` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Global active-low reset (active only in asynchronous mode) |
| a_i | input | A_W | Direct A operand |
| acin_i | input | A_W | Cascade A operand |
| b_i | input | B_W | Direct B operand |
| bcin_i | input | B_W | Cascade B operand |
| d_i | input | D_W | D operand of the pre-adder |
| mode_i | input | 5 | Control word: bit 0 A first-register select, bit 3 subtract, bit 4 B first-register select |
| ce_a1_i | input | 1 | Clock enable, first A register |
| ce_a2_i | input | 1 | Clock enable, second A register |
| ce_b1_i | input | 1 | Clock enable, first B register |
| ce_b2_i | input | 1 | Clock enable, second B register |
| ce_ad_i | input | 1 | Clock enable, pre-adder result register |
| ce_mode_i | input | 1 | Clock enable, control word register |
| rst_a_i | input | 1 | Synchronous reset, both A registers |
| rst_b_i | input | 1 | Synchronous reset, both B registers |
| rst_ad_i | input | 1 | Synchronous reset, pre-adder result register |
| rst_mode_i | input | 1 | Synchronous reset, control word register |
| a_sel_o | output | A_W | A operand toward the multiplier |
| b_sel_o | output | B_W | B operand toward the multiplier |
| ad_o | output | D_W | Pre-adder result |
| acout_o | output | A_W | A cascade output |
| bcout_o | output | B_W | B cascade output |

## Verification
The bench drives inputs on the falling edge and samples 2 ns after the rising edge. Each check names the edge on which its result is due. A control-word change is due one edge later. A first-register operand is due one edge later and a second-register operand two edges later. A registered pre-adder result is due one edge after its operands, so with the default depths it appears three edges after a new A value. The bench checks the value just before the due edge as well as at it, which shows that no result arrives early. Combinational paths (depth 0, and the pre-adder with no result register) are checked 1 ns after the input changes, with no clock edge in between. The asynchronous reset is checked in the middle of a cycle.

// File: rtl/preadd_pkg.sv
package preadd_pkg;
  localparam int MODE_W       = 5;
  localparam int MODE_A_FIRST = 0;
  localparam int MODE_SUB     = 3;
  localparam int MODE_B_FIRST = 4;
  typedef logic [MODE_W-1:0] mode_t;
endpackage

// File: rtl/operand_pipe.sv
module operand_pipe #(
  parameter int W          = 27,
  parameter int DEPTH      = 2,
  parameter bit ASYNC_MODE = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         ce1_i,
  input  logic         ce2_i,
  input  logic         first_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] sel_o,
  output logic [W-1:0] casc_o
);
  logic unused_ok;

  if (DEPTH == 0) begin : g_comb
    assign sel_o     = d_i;
    assign casc_o    = d_i;
    assign unused_ok = ^{clk_i, rst_ni, srst_i, ce1_i, ce2_i, first_i};
  end else begin : g_reg
    logic [W-1:0] s1_q, s2_q, s1_n, s2_n, s2_src;
    // depth 2 chains the stages; depth 1 loads both from the input
    assign s2_src = (DEPTH == 2) ? s1_q : d_i;
    assign s1_n   = srst_i ? '0 : (ce1_i ? d_i : s1_q);
    assign s2_n   = srst_i ? '0 : (ce2_i ? s2_src : s2_q);

    if (ASYNC_MODE) begin : g_async
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          s1_q <= '0;
          s2_q <= '0;
        end else begin
          s1_q <= s1_n;
          s2_q <= s2_n;
        end
      end
      assign unused_ok = 1'b0;
    end else begin : g_sync
      always_ff @(posedge clk_i) begin
        s1_q <= s1_n;
        s2_q <= s2_n;
      end
      assign unused_ok = rst_ni;
    end

    assign sel_o  = first_i ? s1_q : s2_q;
    assign casc_o = s2_q;

    AST_OPERAND_RST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst_i |=> (sel_o == '0 && casc_o == '0)); // R5
    AST_OPERAND_CE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ce1_i && !ce2_i && !srst_i) |=> $stable(casc_o)); // R4
  end
endmodule

// File: rtl/preadd_unit.sv
module preadd_unit #(
  parameter int W          = 27,
  parameter bit AD_REG     = 1'b1,
  parameter bit ASYNC_MODE = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         ce_i,
  input  logic         sub_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] x_i,
  output logic [W-1:0] ad_o
);
  logic [W-1:0] sum;
  logic         unused_ok;

  // wraps modulo 2^W
  assign sum = sub_i ? (d_i - x_i) : (d_i + x_i);

  if (AD_REG) begin : g_reg
    logic [W-1:0] ad_q, ad_n;
    assign ad_n = srst_i ? '0 : (ce_i ? sum : ad_q);
    if (ASYNC_MODE) begin : g_async
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ad_q <= '0;
        else         ad_q <= ad_n;
      end
      assign unused_ok = 1'b0;
    end else begin : g_sync
      always_ff @(posedge clk_i) ad_q <= ad_n;
      assign unused_ok = rst_ni;
    end
    assign ad_o = ad_q;

    AST_AD_RST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst_i |=> (ad_o == '0)); // R9
    AST_AD_CE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ce_i && !srst_i) |=> $stable(ad_o)); // R9
  end else begin : g_comb
    assign ad_o      = sum;
    assign unused_ok = ^{clk_i, rst_ni, srst_i, ce_i};
  end
endmodule

// File: rtl/preadd_operand_stage.sv
module preadd_operand_stage
  import preadd_pkg::*;
#(
  parameter int A_W        = 27,
  parameter int B_W        = 24,
  parameter int D_W        = 27,
  parameter int A_DEPTH    = 2,
  parameter int B_DEPTH    = 1,
  parameter bit AD_REG     = 1'b1,
  parameter bit PRE_SEL_B  = 1'b0,
  parameter bit A_CASC_IN  = 1'b0,
  parameter bit B_CASC_IN  = 1'b0,
  parameter bit ASYNC_MODE = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] a_i,
  input  logic [A_W-1:0] acin_i,
  input  logic [B_W-1:0] b_i,
  input  logic [B_W-1:0] bcin_i,
  input  logic [D_W-1:0] d_i,
  input  logic [4:0]     mode_i,
  input  logic           ce_a1_i,
  input  logic           ce_a2_i,
  input  logic           ce_b1_i,
  input  logic           ce_b2_i,
  input  logic           ce_ad_i,
  input  logic           ce_mode_i,
  input  logic           rst_a_i,
  input  logic           rst_b_i,
  input  logic           rst_ad_i,
  input  logic           rst_mode_i,
  output logic [A_W-1:0] a_sel_o,
  output logic [B_W-1:0] b_sel_o,
  output logic [D_W-1:0] ad_o,
  output logic [A_W-1:0] acout_o,
  output logic [B_W-1:0] bcout_o
);
  mode_t          mode_q, mode_n;
  logic [A_W-1:0] a_src;
  logic [B_W-1:0] b_src;
  logic [D_W-1:0] a_ext, b_ext, pre_x;
  logic           unused_ok;

  assign a_src     = A_CASC_IN ? acin_i : a_i;
  assign b_src     = B_CASC_IN ? bcin_i : b_i;
  assign unused_ok = ^{a_i, acin_i, b_i, bcin_i, mode_q[2:1]};

  assign mode_n = rst_mode_i ? '0 : (ce_mode_i ? mode_t'(mode_i) : mode_q);
  if (ASYNC_MODE) begin : g_mode_async
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q <= '0;
      else         mode_q <= mode_n;
    end
  end else begin : g_mode_sync
    always_ff @(posedge clk_i) mode_q <= mode_n;
  end

  AST_MODE_CE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_mode_i && !rst_mode_i) |=> $stable(mode_q)); // R6

  operand_pipe #(.W(A_W), .DEPTH(A_DEPTH), .ASYNC_MODE(ASYNC_MODE)) u_a_pipe (
    .clk_i, .rst_ni, .srst_i(rst_a_i), .ce1_i(ce_a1_i), .ce2_i(ce_a2_i),
    .first_i(mode_q[MODE_A_FIRST]), .d_i(a_src), .sel_o(a_sel_o), .casc_o(acout_o)
  );

  operand_pipe #(.W(B_W), .DEPTH(B_DEPTH), .ASYNC_MODE(ASYNC_MODE)) u_b_pipe (
    .clk_i, .rst_ni, .srst_i(rst_b_i), .ce1_i(ce_b1_i), .ce2_i(ce_b2_i),
    .first_i(mode_q[MODE_B_FIRST]), .d_i(b_src), .sel_o(b_sel_o), .casc_o(bcout_o)
  );

  assign a_ext = D_W'($signed(a_sel_o));
  assign b_ext = D_W'($signed(b_sel_o));
  assign pre_x = PRE_SEL_B ? b_ext : a_ext;

  preadd_unit #(.W(D_W), .AD_REG(AD_REG), .ASYNC_MODE(ASYNC_MODE)) u_preadd (
    .clk_i, .rst_ni, .srst_i(rst_ad_i), .ce_i(ce_ad_i), .sub_i(mode_q[MODE_SUB]),
    .d_i, .x_i(pre_x), .ad_o
  );
endmodule

// File: tb/preadd_operand_stage_tb.sv
module preadd_operand_stage_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [26:0] a_i, acin_i, d_i;
  logic [23:0] b_i, bcin_i;
  logic [4:0]  mode_i;
  logic ce_a1_i, ce_a2_i, ce_b1_i, ce_b2_i, ce_ad_i, ce_mode_i;
  logic rst_a_i, rst_b_i, rst_ad_i, rst_mode_i;
  logic [26:0] a_sel, ad, acout, a_sel2, ad2, acout2;
  logic [23:0] b_sel, bcout, b_sel2, bcout2;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  preadd_operand_stage u_dut (
    .clk_i(clk), .rst_ni, .a_i, .acin_i, .b_i, .bcin_i, .d_i, .mode_i,
    .ce_a1_i, .ce_a2_i, .ce_b1_i, .ce_b2_i, .ce_ad_i, .ce_mode_i,
    .rst_a_i, .rst_b_i, .rst_ad_i, .rst_mode_i,
    .a_sel_o(a_sel), .b_sel_o(b_sel), .ad_o(ad), .acout_o(acout), .bcout_o(bcout)
  );

  preadd_operand_stage #(
    .A_DEPTH(0), .B_DEPTH(2), .AD_REG(1'b0), .PRE_SEL_B(1'b1),
    .A_CASC_IN(1'b1), .B_CASC_IN(1'b1), .ASYNC_MODE(1'b0)
  ) u_dut2 (
    .clk_i(clk), .rst_ni, .a_i, .acin_i, .b_i, .bcin_i, .d_i, .mode_i,
    .ce_a1_i, .ce_a2_i, .ce_b1_i, .ce_b2_i, .ce_ad_i, .ce_mode_i,
    .rst_a_i, .rst_b_i, .rst_ad_i, .rst_mode_i,
    .a_sel_o(a_sel2), .b_sel_o(b_sel2), .ad_o(ad2), .acout_o(acout2), .bcout_o(bcout2)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic test_reset_state();
    check("R11 reset a_sel", a_sel, 0);
    check("R11 reset acout", acout, 0);
    check("R11 reset b_sel", b_sel, 0);
    check("R11 reset ad", ad, 0);
    check("R5 dut2 b cleared by sync reset", bcout2, 0);
  endtask

  task automatic test_a_latency();
    @(negedge clk); a_i = 27'd5;
    tick();
    check("R1 second-reg path not due after 1 edge", a_sel, 0);
    check("R10 acout not due after 1 edge", acout, 0);
    tick();
    check("R1 second-reg path after 2 edges", a_sel, 5);
    check("R10 acout carries last stage", acout, 5);
    @(negedge clk); a_i = 27'd9; mode_i = 5'b00001;
    tick();
    check("R1 first-reg path after 1 edge", a_sel, 9);
    check("R1 acout still on 2-edge path", acout, 5);
    tick();
    check("R1 acout after 2 edges", acout, 9);
    @(negedge clk); mode_i = 5'b0;
    tick();
  endtask

  task automatic test_preadd();
    @(negedge clk); a_i = 27'd100; d_i = 27'd1000;
    repeat (3) tick();
    check("R7 D plus A", ad, 1100);
    @(negedge clk); mode_i = 5'b01000;
    tick();
    check("R9 ad still holds add result", ad, 1100);
    tick();
    check("R8 D minus A", ad, 900);
    @(negedge clk); a_i = 27'd1; d_i = 27'd0;
    repeat (3) tick();
    check("R8 subtract wraps", ad, 32'h07FF_FFFF);
    @(negedge clk); a_i = 27'h7FF_FFFF; mode_i = 5'b0;
    repeat (3) tick();
    check("R7 add of negative A", ad, 32'h07FF_FFFF);
  endtask

  task automatic test_b_path();
    @(negedge clk); ce_b1_i = 1'b0; b_i = 24'd7;
    tick();
    check("R2 second B reg after 1 edge", b_sel, 7);
    check("R10 bcout", bcout, 7);
    @(negedge clk); mode_i = 5'b10000;
    tick();
    check("R2 first B reg selected", b_sel, 0);
    check("R4 bcout unchanged", bcout, 7);
    @(negedge clk); mode_i = 5'b0; ce_b1_i = 1'b1;
    tick();
  endtask

  task automatic test_ce_hold();
    @(negedge clk); ce_a1_i = 1'b0; ce_a2_i = 1'b0; a_i = 27'd55;
    repeat (3) tick();
    check("R4 acout held", acout, 32'h07FF_FFFF);
    check("R4 a_sel held", a_sel, 32'h07FF_FFFF);
    @(negedge clk); ce_a1_i = 1'b1; ce_a2_i = 1'b1;
    repeat (2) tick();
    check("R4 acout resumes", acout, 55);
    tick();
  endtask

  task automatic test_sync_resets();
    @(negedge clk); ce_ad_i = 1'b0; d_i = 27'd1;
    repeat (2) tick();
    check("R9 ad held with ce low", ad, 55);
    @(negedge clk); ce_ad_i = 1'b1;
    tick();
    check("R9 ad updates", ad, 56);
    @(negedge clk); rst_a_i = 1'b1;
    tick();
    check("R5 acout cleared", acout, 0);
    check("R5 a_sel cleared", a_sel, 0);
    check("R5 B untouched", bcout, 7);
    @(negedge clk); rst_a_i = 1'b0; rst_ad_i = 1'b1;
    tick();
    check("R9 ad cleared", ad, 0);
    @(negedge clk); rst_ad_i = 1'b0;
  endtask

  task automatic test_mode_reg();
    @(negedge clk); a_i = 27'd10; d_i = 27'd20;
    repeat (3) tick();
    check("R7 sum", ad, 30);
    @(negedge clk); ce_mode_i = 1'b0; mode_i = 5'b01000;
    repeat (2) tick();
    check("R6 mode held with ce low", ad, 30);
    @(negedge clk); ce_mode_i = 1'b1;
    repeat (2) tick();
    check("R6 mode captured", ad, 10);
    @(negedge clk); rst_mode_i = 1'b1;
    repeat (2) tick();
    check("R6 mode reset to add", ad, 30);
    @(negedge clk); rst_mode_i = 1'b0; mode_i = 5'b0;
    tick();
  endtask

  task automatic test_depth0_partner_b();
    @(negedge clk); acin_i = 27'd123; bcin_i = 24'hFF_FFFE; d_i = 27'd5;
    #1;
    check("R3 depth 0 a_sel combinational", a_sel2, 123);
    check("R10 cascade input used", acout2, 123);
    tick();
    check("R2 depth 2 B not due", b_sel2, 0);
    tick();
    check("R2 depth 2 B after 2 edges", b_sel2, 32'h00FF_FFFE);
    check("R7 D plus sign-extended B", ad2, 3);
    @(negedge clk); mode_i = 5'b01000;
    tick();
    check("R8 D minus B", ad2, 7);
    @(negedge clk); mode_i = 5'b0;
    tick();
  endtask

  task automatic test_async_reset();
    @(negedge clk); #1 rst_ni = 1'b0;
    #1;
    check("R11 async clears acout", acout, 0);
    check("R11 async clears ad", ad, 0);
    check("R11 async clears bcout", bcout, 0);
    check("R11 ignored in sync mode", bcout2, 32'h00FF_FFFE);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  initial begin
    rst_ni = 1'b0; a_i = '0; acin_i = '0; b_i = '0; bcin_i = '0; d_i = '0; mode_i = '0;
    ce_a1_i = 1'b1; ce_a2_i = 1'b1; ce_b1_i = 1'b1; ce_b2_i = 1'b1;
    ce_ad_i = 1'b1; ce_mode_i = 1'b1;
    rst_a_i = 1'b1; rst_b_i = 1'b1; rst_ad_i = 1'b1; rst_mode_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1; rst_a_i = 1'b0; rst_b_i = 1'b0; rst_ad_i = 1'b0; rst_mode_i = 1'b0;
    #1;
    test_reset_state();
    test_a_latency();
    test_preadd();
    test_b_path();
    test_ce_hold();
    test_sync_resets();
    test_mode_reg();
    test_depth0_partner_b();
    test_async_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule